// File: doc/BRIEF.md
# Rank Refresh Scheduler

This block keeps one DRAM rank's contents alive by scheduling periodic refresh. A free-running timer raises one refresh request per refresh interval (7.8 us by default). Each refresh command covers one group of rows in all eight banks at once. With the default sizes a rank holds 512K rows, or 64K per bank, and 8192 commands fall in each 64 ms retention window. Each command therefore refreshes 8 rows in every bank. The rank is closed to reads and writes for the whole refresh time. That time is 8 rows at 40 ns each, or 320 ns, which is about 4% of the time.

Requests are granted only while the command scheduler reports itself idle. While the scheduler stays busy, requests pile up as postponed refreshes, up to a parameterised limit. The request that would exceed that limit is issued at once whatever the scheduler is doing. Once the scheduler goes idle, the postponed refreshes drain one after another. A row-group pointer shows which rows are being refreshed. It steps through every group of a bank and wraps, so that every row is refreshed once per window.

All durations are parameters in picoseconds and are turned into cycle counts from the clock period. The interval count is rounded down and the busy count is rounded up.

Top module: `rank_refresh_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ref_cmd` and `rank_busy` are 0 and `row_ptr` is 0.
- R2: With the scheduler idle throughout, strobes on `ref_cmd` are exactly INTERVAL_CYC cycles apart (floor of REF_INTERVAL_PS / CLK_PS).
- R3: With the scheduler idle, any window of REFS_PER_WINDOW intervals contains exactly REFS_PER_WINDOW strobes. The `row_ptr` values seen at those strobes cover every row group of a bank.
- R4: `ref_cmd` is a single-cycle pulse. It is high exactly in the first cycle of each `rank_busy` window.
- R5: Each `rank_busy` window lasts BUSY_CYC cycles, the ceiling of ROWS_PER_CMD × ROW_REFRESH_PS / CLK_PS, where ROWS_PER_CMD = RANK_ROWS / BANKS / REFS_PER_WINDOW.
- R6: While `sched_idle` is 0, up to MAX_DEFER due refreshes are postponed and no strobe is issued.
- R7: When the number of due refreshes reaches MAX_DEFER + 1, a refresh is issued even with `sched_idle` at 0. It is issued one interval after the previous one if the scheduler stays busy.
- R8: Once `sched_idle` returns to 1, postponed refreshes are issued back to back. Between consecutive busy windows there is exactly one cycle with `rank_busy` low, so strobes come BUSY_CYC + 1 cycles apart.
- R9: `row_ptr` is the first row, within each bank, of the group being refreshed. It holds steady throughout a busy window and is a multiple of ROWS_PER_CMD. It moves up by ROWS_PER_CMD in the cycle after the window ends and wraps from the last group to 0.
- R10: The first strobe after reset comes INTERVAL_CYC + 1 cycles after the first cycle in which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sched_idle | input | 1 | High when the command scheduler has nothing to issue to this rank |
| ref_cmd | output | 1 | One-cycle strobe: issue a refresh command now |
| rank_busy | output | 1 | High while a refresh occupies the rank; no read or write may be issued |
| row_ptr | output | ROW_W | First row, within each bank, of the group being refreshed or next due |

## Verification
The assertions assume that the busy window is shorter than the refresh interval. Under that assumption the count of due refreshes never goes above MAX_DEFER + 1, and a forced request is always served before the next tick. The stimulus keeps within this assumption by using an interval of 200 cycles and a busy time of 16 cycles. It lowers `sched_idle` only for whole runs of intervals that are aligned to an observed strobe, so the expected strobe cycles can be counted exactly. `sched_idle` changes only on falling clock edges. The bench never holds it low for longer than the forced-refresh case needs.

// File: rtl/refresh_pkg.sv
// Package: shared helpers for the rank refresh scheduler.
// Assumes all durations are given in picoseconds as positive integers.
package refresh_pkg;

    // Round a duration up to a whole number of clock cycles.
    function automatic int ps_to_cyc_ceil(input int dur_ps, input int clk_ps);
        return (dur_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Round a duration down to a whole number of clock cycles.
    function automatic int ps_to_cyc_floor(input int dur_ps, input int clk_ps);
        return dur_ps / clk_ps;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
// Module: refresh_interval_timer
// Free-running counter that pulses `tick` for one cycle every PERIOD_CYC
// cycles. Assumes PERIOD_CYC >= 2. The counter starts at 0 after reset, so
// the first tick comes in the PERIOD_CYC-th cycle after reset is released.
module refresh_interval_timer #(
    parameter int PERIOD_CYC = 6240
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt;

    // Count through one interval and restart at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/refresh_debt_tracker.sv
// Module: refresh_debt_tracker
// Counts refreshes that are due but not yet issued, and decides when one is
// issued. A refresh is granted when the sequencer is ready and either the
// scheduler is idle or the count has passed MAX_DEFER (a forced refresh).
// Assumes the sequencer becomes ready again before the next tick, so the
// count never goes above MAX_DEFER + 1.
module refresh_debt_tracker #(
    parameter int MAX_DEFER = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sched_idle,
    input  logic seq_ready,
    output logic go
);
    localparam int OW = $clog2(MAX_DEFER + 2);
    localparam logic [OW-1:0] LIMIT = OW'(MAX_DEFER);

    logic [OW-1:0] owed;
    logic          must_go;
    logic          any_owed;

    // Decide whether a refresh is granted in this cycle.
    always_comb begin
        any_owed = (owed != '0);
        must_go  = (owed > LIMIT);
        go       = seq_ready && any_owed && (sched_idle || must_go);
    end

    // Add one for each tick and subtract one for each grant.
    always_ff @(posedge clk) begin
        if (!rst_n)            owed <= '0;
        else if (tick && !go)  owed <= owed + 1'b1;
        else if (!tick && go)  owed <= owed - 1'b1;
    end

    // R6
    defer_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !sched_idle) |-> (owed > LIMIT));

    // R7
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(MAX_DEFER + 1));
endmodule

// File: rtl/refresh_busy_seq.sv
// Module: refresh_busy_seq
// On a grant, sends a one-cycle refresh strobe and holds the rank busy for
// BUSY_CYC cycles, starting with the strobe cycle. `done` marks the last busy
// cycle. The sequencer is ready again only when the busy count is zero, so
// there is always at least one idle cycle between two busy windows.
module refresh_busy_seq #(
    parameter int BUSY_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic seq_ready,
    output logic ref_cmd,
    output logic rank_busy,
    output logic done
);
    localparam int BW = $clog2(BUSY_CYC + 1);
    localparam logic [BW-1:0] LOAD = BW'(BUSY_CYC);

    logic [BW-1:0] busy_cnt;

    // Load the busy count on a grant, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy_cnt <= '0;
        else if (go)               busy_cnt <= LOAD;
        else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
    end

    // Register the grant as the command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_cmd <= 1'b0;
        else        ref_cmd <= go;
    end

    assign rank_busy = (busy_cnt != '0);
    assign seq_ready = (busy_cnt == '0);
    assign done      = (busy_cnt == BW'(1));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);

    // R4
    strobe_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rank_busy) |-> ref_cmd);

    // R4
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> rank_busy);
endmodule

// File: rtl/refresh_row_ptr.sv
// Module: refresh_row_ptr
// Holds the first row, within each bank, of the current refresh group.
// Moves up by STEP when `advance` is high and wraps after the last group.
// Assumes BANK_ROWS is a whole multiple of STEP.
module refresh_row_ptr #(
    parameter int BANK_ROWS = 65536,
    parameter int STEP      = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    output logic [$clog2(BANK_ROWS)-1:0] row_ptr
);
    localparam int RW        = $clog2(BANK_ROWS);
    localparam int LAST_BASE = BANK_ROWS - STEP;
    localparam bit POW2      = ((BANK_ROWS & (BANK_ROWS - 1)) == 0);

    logic [RW-1:0] next_ptr;

    generate
        if (POW2) begin : g_natural_wrap
            // Power-of-two bank: the adder overflows to 0 by itself.
            always_comb next_ptr = row_ptr + RW'(STEP);
        end else begin : g_compare_wrap
            // Other sizes: go back to 0 explicitly after the last group.
            always_comb next_ptr = (row_ptr == RW'(LAST_BASE)) ? '0
                                                                : row_ptr + RW'(STEP);
        end
    endgenerate

    // Step the pointer once per finished refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)       row_ptr <= '0;
        else if (advance) row_ptr <= next_ptr;
    end

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(row_ptr));

    // R9
    ptr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ptr % RW'(STEP)) == '0);
endmodule

// File: rtl/rank_refresh_ctrl.sv
// Module: rank_refresh_ctrl (top)
// Periodic refresh scheduler for one DRAM rank. Each command refreshes
// ROWS_PER_CMD rows in every bank in parallel. Intervals and busy time are
// derived from picosecond parameters and the clock period. Assumes
// BUSY_CYC < INTERVAL_CYC and that RANK_ROWS divides evenly by
// BANKS * REFS_PER_WINDOW.
module rank_refresh_ctrl #(
    parameter int CLK_PS          = 1250,
    parameter int REF_INTERVAL_PS = 7800000,
    parameter int ROW_REFRESH_PS  = 40000,
    parameter int RANK_ROWS       = 524288,
    parameter int BANKS           = 8,
    parameter int REFS_PER_WINDOW = 8192,
    parameter int MAX_DEFER       = 8,
    localparam int ROW_W          = $clog2(RANK_ROWS / BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sched_idle,
    output logic             ref_cmd,
    output logic             rank_busy,
    output logic [ROW_W-1:0] row_ptr
);
    import refresh_pkg::*;

    localparam int BANK_ROWS    = RANK_ROWS / BANKS;
    localparam int ROWS_PER_CMD = BANK_ROWS / REFS_PER_WINDOW;
    localparam int INTERVAL_CYC = ps_to_cyc_floor(REF_INTERVAL_PS, CLK_PS);
    localparam int BUSY_CYC     = ps_to_cyc_ceil(ROWS_PER_CMD * ROW_REFRESH_PS, CLK_PS);

    logic tick;
    logic go;
    logic seq_ready;
    logic done;

    refresh_interval_timer #(.PERIOD_CYC(INTERVAL_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    refresh_debt_tracker #(.MAX_DEFER(MAX_DEFER)) u_debt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sched_idle(sched_idle),
        .seq_ready (seq_ready),
        .go        (go)
    );

    refresh_busy_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .seq_ready(seq_ready),
        .ref_cmd  (ref_cmd),
        .rank_busy(rank_busy),
        .done     (done)
    );

    refresh_row_ptr #(.BANK_ROWS(BANK_ROWS), .STEP(ROWS_PER_CMD)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(done),
        .row_ptr(row_ptr)
    );

    // R9
    ptr_stable_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_busy && $past(rank_busy)) |-> $stable(row_ptr));

    // R8
    grant_not_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !rank_busy);
endmodule

// File: tb/rank_refresh_ctrl_tb_top.sv
// Directed bench for rank_refresh_ctrl using a scaled configuration:
// 200-cycle interval, 16-cycle busy window, 64 rows per bank in groups of 8.
module rank_refresh_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IVL        = 200;
    localparam int BUSY       = 16;
    localparam int STEP       = 8;
    localparam int BROWS      = 64;
    localparam int GROUPS     = 8;
    localparam int DEFER      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sched_idle = 1'b1;
    logic       ref_cmd;
    logic       rank_busy;
    logic [5:0] row_ptr;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rank_refresh_ctrl #(
        .CLK_PS(1000), .REF_INTERVAL_PS(200000), .ROW_REFRESH_PS(2000),
        .RANK_ROWS(512), .BANKS(8), .REFS_PER_WINDOW(8), .MAX_DEFER(DEFER)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sched_idle(sched_idle),
        .ref_cmd(ref_cmd), .rank_busy(rank_busy), .row_ptr(row_ptr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pointer sequence, strobe placement, busy length, strobe spacing.
    int  exp_ptr = 0;
    int  run = 0;
    bit  prev_busy = 1'b0;
    int  cyc = 0;
    int  last_strobe = -1;
    always @(negedge clk) begin
        if (mon_en) begin
            cyc++;
            if (ref_cmd) begin
                check(int'(row_ptr) == exp_ptr, "R9 row_ptr at strobe", row_ptr, exp_ptr);
                exp_ptr = (exp_ptr + STEP) % BROWS;
                check(rank_busy && !prev_busy, "R4 strobe opens busy window",
                      {prev_busy, rank_busy}, 1);
                if (last_strobe >= 0)
                    check(cyc - last_strobe >= BUSY + 1, "R8 strobe spacing minimum",
                          cyc - last_strobe, BUSY + 1);
                last_strobe = cyc;
            end
            if (rank_busy) run++;
            else if (prev_busy) begin
                check(run == BUSY, "R5 busy window length", run, BUSY);
                run = 0;
            end
            prev_busy = rank_busy;
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!ref_cmd);
    endtask

    task automatic t_reset();
        int early = 0;
        int got = 0;
        rst_n = 1'b0;
        sched_idle = 1'b1;
        repeat (3) @(negedge clk);
        check(!ref_cmd && !rank_busy && row_ptr == 0, "R1 outputs in reset",
              {ref_cmd, rank_busy, row_ptr}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        for (int i = 1; i <= IVL + 1; i++) begin
            @(negedge clk);
            if (i == 1)
                check(!ref_cmd && !rank_busy && row_ptr == 0, "R1 outputs after release",
                      {ref_cmd, rank_busy, row_ptr}, 0);
            if (ref_cmd && i <= IVL) early++;
            if (i == IVL + 1) got = ref_cmd;
        end
        check(early == 0, "R10 no early strobe", early, 0);
        check(got == 1, "R10 first strobe timing", got, 1);
    endtask

    task automatic t_steady();
        int cnt = 0;
        bit [GROUPS-1:0] seen = '0;
        wait_strobe();
        for (int i = 1; i <= GROUPS * IVL; i++) begin
            @(negedge clk);
            if (ref_cmd) begin
                cnt++;
                seen[row_ptr / STEP] = 1'b1;
                check((i % IVL) == 0, "R2 strobe period", i % IVL, 0);
            end
        end
        check(cnt == GROUPS, "R3 strobes per window", cnt, GROUPS);
        check(seen == '1, "R3 all row groups covered", seen, 255);
    endtask

    task automatic t_defer();
        int early = 0;
        int cnt = 0;
        wait_strobe();
        sched_idle = 1'b0;
        for (int i = 1; i <= 5 * IVL; i++) begin
            @(negedge clk);
            if (ref_cmd) early++;
        end
        sched_idle = 1'b1;
        check(early == 0, "R6 postponed while scheduler busy", early, 0);
        for (int j = 1; j <= 100; j++) begin
            @(negedge clk);
            if (ref_cmd) begin
                cnt++;
                check(((j - 1) % (BUSY + 1)) == 0, "R8 back-to-back drain spacing",
                      j, 1 + (cnt - 1) * (BUSY + 1));
            end
        end
        check(cnt == 5, "R8 drained count", cnt, 5);
    endtask

    task automatic t_force();
        int cnt = 0;
        int pos = 0;
        wait_strobe();
        sched_idle = 1'b0;
        for (int i = 1; i <= (DEFER + 1) * IVL; i++) begin
            @(negedge clk);
            if (ref_cmd) begin cnt++; pos = i; end
        end
        check(cnt == 1, "R7 one forced strobe", cnt, 1);
        check(pos == (DEFER + 1) * IVL, "R7 forced strobe cycle", pos, (DEFER + 1) * IVL);
        cnt = 0; pos = 0;
        for (int i = 1; i <= IVL; i++) begin
            @(negedge clk);
            if (ref_cmd) begin cnt++; pos = i; end
        end
        check(cnt == 1 && pos == IVL, "R7 repeat forced strobe", pos, IVL);
        sched_idle = 1'b1;
        cnt = 0;
        for (int j = 1; j <= 160; j++) begin
            @(negedge clk);
            if (ref_cmd) cnt++;
        end
        check(cnt == DEFER, "R8 drain after forced", cnt, DEFER);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_steady();
        t_defer();
        t_force();
        t_steady();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end
endmodule